// File: doc/BRIEF.md
# Serial Sequential Read Streamer

This block produces the serial output side of a read command in a serial memory device. A command front end decodes the command. When it has latched the final address bit it pulses `start` with the first word address. The streamer then answers with one low bit and goes on to shift out 16-bit words from a synchronous memory array, most significant bit first. It moves one bit for each rising edge of the serial clock. The rising edges arrive as single-cycle `sk_rise` strobes in the system clock domain.

After the least significant bit of a word, the next rising edge carries the top bit of the following word. That word's address is the current address plus one, and it wraps from all ones back to zero. The stream has no length limit and ends only when chip select drops. While a word is being shifted, the next word is read from the array so that it is ready in time. The array is a plain fixed-latency port: an enable and an address in one cycle, data in the next. The serial clock fixes the pace of the output, so neither side can apply back-pressure and the block has no ready signal. Both strobes must be at least two system cycles apart, and the first `sk_rise` may come no earlier than two cycles after `start`.

Top module: `seq_read_streamer`

## Requirements
- R1: While reset is asserted and after it is released, `doe`, `dout` and `mem_en` are 0 until a read is started.
- R2: A `start` pulse with `cs` high gives `doe`=1 and `dout`=0 (the leading zero) in the next cycle. In the same cycle as the pulse, `mem_en` is 1 and `mem_addr` equals `start_addr`.
- R3: Each `sk_rise` during a read shifts out the next bit of the current word, bit 15 first and bit 0 last. `dout` takes the new bit in the cycle after the strobe.
- R4: The `sk_rise` after bit 0 of a word, and the first strobe after the leading zero, put out bit 15 of the next word with no gap. The address of each new word is one more than that of the previous word.
- R5: The address after the all-ones address is zero.
- R6: When `cs` is low, `doe` and `dout` are 0 in the next cycle. Later `sk_rise` strobes have no effect on `doe`, `dout` or `mem_en` until a new start.
- R7: A `start` pulse while `cs` is low is ignored: `doe` stays 0 and no memory read is made.
- R8: `dout` changes only in the cycle after an `sk_rise`, after a `start`, or after `cs` goes low.
- R9: Each word is read from the array exactly once. A read happens only on an accepted start, and on the strobe that puts out bit 15 of the word before it. A read of N words therefore makes N+1 memory requests.
- R10: A `start` during an active read restarts the stream at the new address with a fresh leading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select level; high enables the stream |
| sk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| start | input | 1 | One-cycle strobe from the front end: last address bit latched |
| start_addr | input | AW | First word address of the read |
| mem_en | output | 1 | Array read enable |
| mem_addr | output | AW | Array read address |
| mem_rdata | input | DW | Array read data, valid one cycle after `mem_en` |
| dout | output | 1 | Serial data bit |
| doe | output | 1 | Output enable for the tri-state data pin |

## Verification
The assertions check on every cycle that the leading zero follows each accepted start, that chip select going low turns the output enable off, and that the output enable rises only after a start. They also check that `dout` holds still between strobes, and that memory requests come only from a start or a strobe with addresses that step by one and wrap. Only the bench scenarios can show that the right bits of the right words come out in order. The bench checks this at every start address of a small array, with streams long enough to cross the wrap. It also checks the one-fetch-per-word count, a restart in the middle of a word, and that strobes and starts are ignored while chip select is low.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned SRS_WORD_W = 16;

  function automatic int unsigned srs_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/srs_fetch.sv
module srs_fetch #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_start,
  input  logic          launch_next,
  input  logic [AW-1:0] start_addr,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] nxt_word
);
  logic [AW-1:0] word_addr_q;
  logic [AW-1:0] succ_addr;
  logic          fill_q;
  logic [DW-1:0] nxt_q;

  // natural AW-bit overflow provides the wrap to zero
  assign succ_addr = word_addr_q + AW'(1);
  assign mem_en    = launch_start | launch_next;
  assign mem_addr  = launch_start ? start_addr : succ_addr;
  assign nxt_word  = nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr_q <= '0;
      fill_q      <= 1'b0;
      nxt_q       <= '0;
    end else begin
      fill_q <= mem_en;
      if (launch_start)     word_addr_q <= start_addr;
      else if (launch_next) word_addr_q <= succ_addr;
      if (fill_q) nxt_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/srs_shift.sv
module srs_shift #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          lead,
  input  logic          step,
  input  logic [DW-1:0] nxt_word,
  output logic          need_word,
  output logic          dout
);
  localparam int unsigned CW = srs_pkg::srs_cnt_w(DW);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] left_q;
  logic          dout_q;

  assign need_word = (left_q == '0);
  assign dout      = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      dout_q <= 1'b0;
    end else if (clear || lead) begin
      left_q <= '0;
      dout_q <= 1'b0;
    end else if (step) begin
      if (need_word) begin
        dout_q <= nxt_word[DW-1];
        sh_q   <= nxt_word << 1;
        left_q <= CW'(DW-1);
      end else begin
        dout_q <= sh_q[DW-1];
        sh_q   <= sh_q << 1;
        left_q <= left_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/seq_read_streamer.sv
module seq_read_streamer #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = srs_pkg::SRS_WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk_rise,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          dout,
  output logic          doe
);
  logic          active_q;
  logic          start_ok;
  logic          step;
  logic          need_word;
  logic [DW-1:0] nxt_word;

  assign start_ok = start & cs;
  assign step     = sk_rise & cs & active_q & ~start_ok;
  assign doe      = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active_q <= 1'b0;
    else if (!cs)      active_q <= 1'b0;
    else if (start_ok) active_q <= 1'b1;
  end

  srs_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_start (start_ok),
    .launch_next  (step & need_word),
    .start_addr   (start_addr),
    .mem_en       (mem_en),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .nxt_word     (nxt_word)
  );

  srs_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (~cs),
    .lead      (start_ok),
    .step      (step),
    .nxt_word  (nxt_word),
    .need_word (need_word),
    .dout      (dout)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          sk_rise,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic          dout,
  input logic          doe
);
  logic [AW-1:0] last_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_addr_q <= '0;
    else if (mem_en) last_addr_q <= mem_addr;
  end

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cs) |=> (doe && !dout));

  // R2
  start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cs) |-> (mem_en && mem_addr == start_addr));

  // R6
  cs_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !doe);

  // R7
  doe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doe) |-> $past(start && cs));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs) && !$past(sk_rise) && !$past(start)) |-> $stable(dout));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !(start && cs)) |-> (mem_addr == last_addr_q + AW'(1)));

  // R9
  fetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (cs && (start || sk_rise)));
endmodule

bind seq_read_streamer srs_chk #(.AW(AW)) u_srs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .sk_rise    (sk_rise),
  .start      (start),
  .start_addr (start_addr),
  .mem_en     (mem_en),
  .mem_addr   (mem_addr),
  .dout       (dout),
  .doe        (doe)
);

// File: tb/seq_read_streamer_bench.sv
module seq_read_streamer_bench;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 16;
  localparam int unsigned NWORDS = 1 << AW;
  localparam int unsigned RUN = NWORDS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic          sk_rise = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          mem_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          dout;
  logic          doe;

  int checks = 0;
  int failures = 0;
  int reqs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seq_read_streamer #(.AW(AW), .DW(DW)) u_seq_read_streamer (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .start(start),
    .start_addr(start_addr), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dout(dout), .doe(doe)
  );

  function automatic logic [DW-1:0] word_of(input int unsigned a);
    return DW'(16'hB3A1 ^ (a * 16'h2F09));
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= word_of(mem_addr);
      reqs <= reqs + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input int unsigned a, input string req);
    start = 1'b1;
    start_addr = AW'(a);
    @(negedge clk);
    start = 1'b0;
    chk(doe == 1'b1 && dout == 1'b0, req, {doe, dout}, 2'b10);
    @(negedge clk);
  endtask

  task automatic sk_pulse(output logic b);
    sk_rise = 1'b1;
    @(negedge clk);
    sk_rise = 1'b0;
    b = dout;
    @(negedge clk);
    chk(dout == b, "R8", dout, b);
  endtask

  task automatic read_word(input int unsigned a, input string req);
    logic [DW-1:0] w;
    logic b;
    w = word_of(a);
    for (int i = DW - 1; i >= 0; i--) begin
      sk_pulse(b);
      chk(b == w[i], (i == DW - 1) ? req : "R3", b, w[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic b;
    int snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(doe == 1'b0 && dout == 1'b0 && mem_en == 1'b0, "R1", {doe, dout, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(doe == 1'b0 && dout == 1'b0 && mem_en == 1'b0, "R1", {doe, dout, mem_en}, 0);

    // sweep every start address; streams cross the wrap (R4, R5, R9)
    for (int a = 0; a < int'(NWORDS); a++) begin
      cs = 1'b1;
      @(negedge clk);
      snap = reqs;
      do_start(a, "R2");
      for (int k = 0; k < int'(RUN); k++) begin
        int unsigned ad;
        ad = (a + k) % NWORDS;
        read_word(ad, (k > 0 && ad == 0) ? "R5" : "R4");
      end
      chk(reqs - snap == int'(RUN) + 1, "R9", reqs - snap, RUN + 1);
      cs = 1'b0;
      @(negedge clk);
      chk(doe == 1'b0 && dout == 1'b0, "R6", {doe, dout}, 0);
    end

    // R6: strobes ignored while cs low
    snap = reqs;
    for (int i = 0; i < 4; i++) sk_pulse(b);
    chk(doe == 1'b0 && dout == 1'b0 && reqs == snap, "R6", {doe, dout}, 0);

    // R7: start with cs low ignored
    start = 1'b1;
    start_addr = AW'(3);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(doe == 1'b0 && reqs == snap, "R7", reqs - snap, 0);

    // R10: restart mid-word
    cs = 1'b1;
    @(negedge clk);
    do_start(2, "R2");
    for (int i = 0; i < 5; i++) sk_pulse(b);
    do_start(6, "R10");
    read_word(6, "R10");
    read_word(7, "R4");
    read_word(0, "R5");

    // R6: cs drop mid-word stops the stream
    for (int i = 0; i < 3; i++) sk_pulse(b);
    cs = 1'b0;
    @(negedge clk);
    chk(doe == 1'b0 && dout == 1'b0, "R6", {doe, dout}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule